// File: doc/BRIEF.md
# SMBus Block Payload Buffer

This block is a byte-wide first-in first-out buffer. It holds the payload of a block transfer while it moves between a software register port and the SMBus master engine. Before a block write, software loads the payload one byte per write strobe. While the engine transmits, it drains the buffer. While the engine receives a block read, it fills the buffer, and software empties it afterwards through the same port.

The engine-busy input decides who may use the buffer. While busy is high, only the engine's valid/ready streams move data, and software strobes do nothing. While busy is low, only software strobes move data, and both engine streams hold their handshake signals low. Transmit stream: `tx_valid` is high while busy is high and the buffer holds at least one byte. A byte leaves in every cycle where `tx_valid` and `tx_ready` are both high. Receive stream: `rx_ready` is high while busy is high and the buffer is not full. A byte enters in every cycle where `rx_valid` and `rx_ready` are both high. The engine applies back-pressure by holding `tx_ready` low. The buffer applies back-pressure by dropping `rx_ready`.

When the engine reports a transfer error, the buffer discards everything in a single cycle. The fill count lets the engine compare progress against the programmed block length.

Top module: `smb_blk_fifo`

## Requirements
- R1: After reset, `fill_cnt` is 0, `ovf_flag` is 0, `sw_rdata` is 00h, and `tx_valid` and `rx_ready` are both low.
- R2: While busy is low, a `sw_wr_en` strobe into a non-full buffer stores `sw_wdata` and raises `fill_cnt` by one at the next clock edge. Software reads then return the bytes in the order they were written.
- R3: The buffer holds at most 32 bytes. `fill_cnt` reaches exactly 32 (6 bits wide) and never exceeds it, and `rx_ready` is low whenever the buffer is full.
- R4: A software write into a full buffer while busy is low is dropped: the count stays at 32 and the stored bytes are unchanged. It also sets `ovf_flag`, which stays set until a flush or reset clears it.
- R5: While the buffer is empty, `sw_rdata` is 00h. A software read strobe from an empty buffer leaves `fill_cnt` at 0.
- R6: While busy is high, software write and read strobes have no effect: nothing is stored, nothing is consumed, `fill_cnt` and `sw_rdata` hold, and `ovf_flag` is not set.
- R7: `tx_valid` is high exactly when busy is high and the buffer is not empty. `tx_data` shows the oldest byte, and each cycle with `tx_valid` and `tx_ready` both high removes one byte in write order.
- R8: `rx_ready` is high exactly when busy is high and the buffer is not full. Each cycle with `rx_valid` and `rx_ready` both high stores `rx_data` behind the bytes already held.
- R9: A cycle with `xfer_err` high empties the buffer at the next clock edge (`fill_cnt` becomes 0 and `ovf_flag` is cleared), regardless of any push or pop requested in that same cycle.
- R10: `fill_cnt` always equals the number of accepted pushes minus accepted pops since the last reset or flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_busy | input | 1 | Engine owns the buffer when high |
| xfer_err | input | 1 | Transfer error, flushes the buffer |
| sw_wr_en | input | 1 | Software write strobe on the access port |
| sw_wdata | input | 8 | Software write byte |
| sw_rd_en | input | 1 | Software read strobe, consumes the head byte |
| sw_rdata | output | 8 | Head byte, or 00h when empty |
| tx_valid | output | 1 | Transmit stream byte available |
| tx_ready | input | 1 | Engine accepts the transmit byte |
| tx_data | output | 8 | Transmit stream byte |
| rx_valid | input | 1 | Engine offers a received byte |
| rx_ready | output | 1 | Buffer accepts the received byte |
| rx_data | input | 8 | Received byte |
| fill_cnt | output | 6 | Bytes currently held |
| ovf_flag | output | 1 | Sticky software overflow indication |

## Verification
The hardest situation to reach from the ports is the pointer wrap combined with a boundary fill level. Reaching it needs a full buffer whose write and read pointers sit at an arbitrary offset, then a dropped write and a flush on top. The stimulus sweeps every block length from 1 to 32 across successive runs without a flush between them, so the pointers start each run at a different position. The overflow and flush cases are then applied to a buffer whose pointers have already wrapped many times. The engine streams are driven with the software strobes held active at the same time, to show that the busy gate keeps the two sides apart.

// File: rtl/smb_blk_fifo_pkg.sv
package smb_blk_fifo_pkg;
  typedef logic [7:0] byte_t;

  typedef struct packed {
    logic  push;
    logic  pop;
    logic  ovf_hit;
    byte_t wdata;
  } fifo_op_t;
endpackage

// File: rtl/smb_blk_fifo_gate.sv
module smb_blk_fifo_gate
  import smb_blk_fifo_pkg::*;
(
  input  logic     host_busy,
  input  logic     full,
  input  logic     empty,
  input  logic     sw_wr_en,
  input  byte_t    sw_wdata,
  input  logic     sw_rd_en,
  input  logic     tx_ready,
  input  logic     rx_valid,
  input  byte_t    rx_data,
  output logic     tx_valid,
  output logic     rx_ready,
  output fifo_op_t op
);
  logic sw_push, sw_pop, eng_push, eng_pop;

  // engine side only live while busy
  assign tx_valid = host_busy & ~empty;
  assign rx_ready = host_busy & ~full;
  assign eng_push = rx_valid & rx_ready;
  assign eng_pop  = tx_valid & tx_ready;

  // software side only live while idle
  assign sw_push = ~host_busy & sw_wr_en & ~full;
  assign sw_pop  = ~host_busy & sw_rd_en & ~empty;

  always_comb begin
    op.push    = sw_push | eng_push;
    op.pop     = sw_pop | eng_pop;
    op.ovf_hit = ~host_busy & sw_wr_en & full;
    op.wdata   = host_busy ? rx_data : sw_wdata;
  end
endmodule

// File: rtl/smb_blk_fifo_ctrl.sv
module smb_blk_fifo_ctrl #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] cnt,
  output logic          full,
  output logic          empty
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/smb_blk_fifo_store.sv
module smb_blk_fifo_store
  import smb_blk_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  byte_t         wdata,
  input  logic [AW-1:0] raddr,
  output byte_t         rdata
);
  byte_t mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mem_q[g] <= '0;
      else if (we && waddr == AW'(g))      mem_q[g] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/smb_blk_fifo.sv
module smb_blk_fifo
  import smb_blk_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_busy,
  input  logic          xfer_err,
  input  logic          sw_wr_en,
  input  logic [7:0]    sw_wdata,
  input  logic          sw_rd_en,
  output logic [7:0]    sw_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [7:0]    rx_data,
  output logic [CW-1:0] fill_cnt,
  output logic          ovf_flag
);
  fifo_op_t      op;
  logic          full, empty;
  logic [AW-1:0] wptr, rptr;
  byte_t         head;

  smb_blk_fifo_gate u_gate (
    .host_busy (host_busy),
    .full      (full),
    .empty     (empty),
    .sw_wr_en  (sw_wr_en),
    .sw_wdata  (sw_wdata),
    .sw_rd_en  (sw_rd_en),
    .tx_ready  (tx_ready),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .tx_valid  (tx_valid),
    .rx_ready  (rx_ready),
    .op        (op)
  );

  smb_blk_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (xfer_err),
    .push  (op.push),
    .pop   (op.pop),
    .wptr  (wptr),
    .rptr  (rptr),
    .cnt   (fill_cnt),
    .full  (full),
    .empty (empty)
  );

  smb_blk_fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (op.push & ~xfer_err),
    .waddr (wptr),
    .wdata (op.wdata),
    .raddr (rptr),
    .rdata (head)
  );

  assign sw_rdata = empty ? 8'h00 : head;
  assign tx_data  = head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ovf_flag <= 1'b0;
    else if (xfer_err)   ovf_flag <= 1'b0;
    else if (op.ovf_hit) ovf_flag <= 1'b1;
  end
endmodule

// File: rtl/smb_blk_fifo_chk.sv
module smb_blk_fifo_chk #(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_busy,
  input logic          xfer_err,
  input logic          sw_wr_en,
  input logic          sw_rd_en,
  input logic [7:0]    sw_rdata,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic [CW-1:0] fill_cnt,
  input logic          ovf_flag
);
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CW'(DEPTH)); // R3
  AST_FULL_NO_RX: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt == CW'(DEPTH) |-> !rx_ready); // R3
  AST_FULL_WR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_err && !host_busy && sw_wr_en && fill_cnt == CW'(DEPTH)
    |=> ovf_flag && fill_cnt == CW'(DEPTH)); // R4
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt == '0 |-> sw_rdata == 8'h00); // R5
  AST_BUSY_SW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    host_busy && !xfer_err && !rx_valid && !tx_ready |=> $stable(fill_cnt)); // R6
  AST_IDLE_NO_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    !host_busy |-> !tx_valid && !rx_ready); // R7
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |=> fill_cnt == '0 && !ovf_flag); // R9
endmodule

bind smb_blk_fifo smb_blk_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_busy (host_busy),
  .xfer_err  (xfer_err),
  .sw_wr_en  (sw_wr_en),
  .sw_rd_en  (sw_rd_en),
  .sw_rdata  (sw_rdata),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .fill_cnt  (fill_cnt),
  .ovf_flag  (ovf_flag)
);

// File: tb/sim_smb_blk_fifo.sv
`timescale 1ns/1ps
module sim_smb_blk_fifo;
  localparam int DEPTH = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_busy = 1'b0, xfer_err = 1'b0;
  logic       sw_wr_en = 1'b0, sw_rd_en = 1'b0;
  logic [7:0] sw_wdata = '0, sw_rdata;
  logic       tx_valid, tx_ready = 1'b0;
  logic [7:0] tx_data;
  logic       rx_valid = 1'b0, rx_ready;
  logic [7:0] rx_data = '0;
  logic [5:0] fill_cnt;
  logic       ovf_flag;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  smb_blk_fifo #(.DEPTH(DEPTH)) u0 (.*);

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] pat(int run, int i);
    return 8'((run * 37 + i * 11 + 5) & 8'hFF);
  endfunction

  task automatic sw_write(logic [7:0] d);
    sw_wr_en = 1'b1; sw_wdata = d; tick(); sw_wr_en = 1'b0;
  endtask

  task automatic sw_read_chk(string req, logic [7:0] exp);
    check(req, int'(sw_rdata), int'(exp));
    sw_rd_en = 1'b1; tick(); sw_rd_en = 1'b0;
  endtask

  task automatic flush();
    xfer_err = 1'b1; tick(); xfer_err = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check("R1 cnt", fill_cnt, 0);
    check("R1 ovf", ovf_flag, 0);
    check("R1 rdata", sw_rdata, 0);
    check("R1 tx_valid", tx_valid, 0);
    check("R1 rx_ready", rx_ready, 0);
    rst_n = 1'b1;
    tick();

    // R2 / R10 sweep all block lengths, pointers drift between runs
    for (int n = 1; n <= DEPTH; n++) begin
      for (int i = 0; i < n; i++) begin
        sw_write(pat(n, i));
        check("R10 cnt up", fill_cnt, i + 1);
      end
      check("R3 level", fill_cnt, n);
      for (int i = 0; i < n; i++) sw_read_chk("R2 order", pat(n, i));
      check("R10 cnt drained", fill_cnt, 0);
    end

    // R5 read from empty
    check("R5 empty data", sw_rdata, 0);
    sw_rd_en = 1'b1; tick(); sw_rd_en = 1'b0;
    check("R5 cnt stays", fill_cnt, 0);

    // R3 / R4 overflow on a wrapped buffer
    for (int i = 0; i < DEPTH; i++) sw_write(pat(99, i));
    check("R3 full cnt", fill_cnt, DEPTH);
    check("R4 ovf before", ovf_flag, 0);
    sw_write(8'hEE);
    check("R4 cnt held", fill_cnt, DEPTH);
    check("R4 ovf set", ovf_flag, 1);
    host_busy = 1'b1; @(negedge clk);
    check("R3 rx_ready full", rx_ready, 0);
    host_busy = 1'b0;
    for (int i = 0; i < DEPTH; i++) sw_read_chk("R4 data kept", pat(99, i));
    check("R4 ovf sticky", ovf_flag, 1);
    check("R4 empty after", sw_rdata, 0);

    // R9 flush clears ovf, dominates a same-cycle write
    sw_write(8'h12); sw_write(8'h34);
    sw_wr_en = 1'b1; sw_wdata = 8'h56; xfer_err = 1'b1; tick();
    sw_wr_en = 1'b0; xfer_err = 1'b0;
    check("R9 cnt", fill_cnt, 0);
    check("R9 ovf", ovf_flag, 0);
    check("R9 rdata", sw_rdata, 0);

    // R6 busy gates software
    sw_write(8'hA1); sw_write(8'hA2); sw_write(8'hA3);
    host_busy = 1'b1;
    sw_wr_en = 1'b1; sw_rd_en = 1'b1; sw_wdata = 8'h77;
    repeat (3) tick();
    sw_wr_en = 1'b0; sw_rd_en = 1'b0;
    check("R6 cnt", fill_cnt, 3);
    check("R6 rdata", sw_rdata, 8'hA1);
    // R7 drain via engine with software strobes still active
    sw_wr_en = 1'b1; sw_rd_en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      check("R7 tx_valid", tx_valid, 1);
      check("R7 tx_data", tx_data, 8'hA1 + i);
      tx_ready = 1'b1; tick(); tx_ready = 1'b0;
    end
    check("R7 tx_valid empty", tx_valid, 0);
    check("R6 no sw push", fill_cnt, 0);
    sw_wr_en = 1'b0; sw_rd_en = 1'b0;

    // R6 busy write into full buffer leaves ovf clear
    // R8 engine fill to capacity with back-pressure
    for (int i = 0; i < DEPTH + 3; i++) begin
      check("R8 rx_ready", rx_ready, (i < DEPTH) ? 1 : 0);
      rx_valid = 1'b1; rx_data = pat(7, i); tick();
    end
    rx_valid = 1'b0;
    check("R8 cnt full", fill_cnt, DEPTH);
    sw_wr_en = 1'b1; tick(); sw_wr_en = 1'b0;
    check("R6 no ovf", ovf_flag, 0);
    // tx and rx in the same cycle keep the count
    tx_ready = 1'b1; tick(); tx_ready = 1'b0;
    rx_valid = 1'b1; tx_ready = 1'b1; rx_data = 8'hC3; tick();
    rx_valid = 1'b0; tx_ready = 1'b0;
    check("R10 simultaneous", fill_cnt, DEPTH - 1);
    host_busy = 1'b0; @(negedge clk);
    check("R7 idle tx_valid", tx_valid, 0);
    for (int i = 2; i < DEPTH; i++) sw_read_chk("R8 rx order", pat(7, i));
    sw_read_chk("R8 rx tail", 8'hC3);
    check("R10 end", fill_cnt, 0);

    // R9 flush of a partly filled engine buffer
    host_busy = 1'b1;
    for (int i = 0; i < 5; i++) begin
      rx_valid = 1'b1; rx_data = 8'(i); tick();
    end
    rx_valid = 1'b1; xfer_err = 1'b1; tick();
    rx_valid = 1'b0; xfer_err = 1'b0; host_busy = 1'b0;
    check("R9 engine flush", fill_cnt, 0);
    sw_write(8'h5A);
    sw_read_chk("R9 fresh after flush", 8'h5A);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule